// File: doc/BRIEF.md
# Double-Buffered Parallel DAC Code Loader

This block is the digital front end of an 8-bit digital-to-analog converter. It has an 8-bit parallel data bus and four active-low controls: a chip select, a write strobe, a load strobe and a clear. All controls are asynchronous to the fast system clock. They pass through a two-flop synchronizer, and their edges are detected on the clock. The block drives the 8-bit code into the converter, plus a one-cycle pulse that marks each transfer into the output register.

A write lasts while select and write strobe are both low. It ends at whichever of the two rises first, and at that point the bus value is captured into an input register. The level of the load strobe at that same instant decides what happens next. If the load strobe is low, the code register follows at once (immediate mode). If it is high, the code register keeps its value until the next falling edge of the load strobe (deferred mode), which lets several converters change output together.

An asynchronous clear zeroes both registers without waiting for a clock edge. An internal power-on strobe, low for a fixed number of cycles after reset, also holds both registers at zero.

Top module: `dac_loader`

## Requirements
- R1: After reset, `code_out` is 0 and `code_upd` is 0. For POR_CYCLES clock cycles after reset release, both the input register and the code register are held at 0, and any write completing in that window leaves no trace.
- R2: A write exists only while `sel_n` and `wstb_n` are both low. It ends when the first of them rises, and the value on `bus_d` at that moment is captured. Bus changes after the end of the write, and write-strobe pulses while `sel_n` is high, change neither register.
- R3: If `load_n` is low when a write ends, `code_out` takes the captured value. The bit order is `code_out[i]` = `bus_d[i]`, so bit 7 is the most significant bit.
- R4: If `load_n` is high when a write ends, `code_out` keeps its previous value. On the next falling edge of `load_n`, `code_out` takes the captured value.
- R5: A falling edge of `load_n` with no deferred write outstanding reloads the code register from the input register. The code is unchanged, and `code_upd` still pulses.
- R6: While `zero_n` is low, `code_out` is 0 immediately, with no clock edge needed. After release, both registers stay 0 until the next completed write, so a later `load_n` falling edge yields 0.
- R7: `code_upd` is high for exactly one cycle for each transfer into the code register, and for nothing else. A deferred write and a clear do not raise it.
- R8: `code_out` and `code_upd` change on the third rising clock edge after the strobe transition that causes the transfer. The first two edges pass through the synchronizer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the strobes |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_d | input | CODE_W | Parallel data bus, bit 7 most significant |
| sel_n | input | 1 | Active-low chip select |
| wstb_n | input | 1 | Active-low write strobe |
| load_n | input | 1 | Active-low load strobe; its level at the end of a write chooses the mode |
| zero_n | input | 1 | Asynchronous active-low clear of both registers |
| code_out | output | CODE_W | Code to the converter |
| code_upd | output | 1 | One-cycle pulse on each transfer into the code register |

## Verification
The hardest situation to reach from the ports is the deferred path. The load strobe must already be high when the write ends, and only a later falling edge may release the value. That falling edge is not allowed to come from the bench's own lowering of the load strobe just before an immediate write. The stimulus therefore raises the load strobe several cycles before it ends a deferred write. It issues every falling edge through a dedicated task that advances the reference model. Random sequences then mix deferred writes, bare load edges, clears with a write outstanding, and stray write strobes without select.

// File: rtl/dacl_pkg.sv
package dacl_pkg;
  localparam int unsigned CODE_W_DEF = 8;
  localparam int unsigned SYNC_DEF   = 2;
  localparam int unsigned POR_DEF    = 16;

  typedef struct packed {
    logic sel_n;
    logic wstb_n;
    logic load_n;
  } strobe_t;

  localparam strobe_t STROBE_IDLE = '{sel_n: 1'b1, wstb_n: 1'b1, load_n: 1'b1};
endpackage

// File: rtl/dacl_sync.sv
module dacl_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[0] <= RST_VAL;
        else        chain_q[0] <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/dacl_por.sv
module dacl_por #(
  parameter int unsigned CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n,
  output logic por_n
);
  localparam int unsigned CW = $clog2(CYCLES + 1);

  logic [1:0]    rsync_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d, cnt_en;

  // reset asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s_n = rsync_q[1];

  always_comb begin
    cnt_en = !done_q;
    cnt_d  = cnt_q + 1'b1;
    done_d = (cnt_q == CW'(CYCLES - 1));
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign por_n = done_q;
endmodule

// File: rtl/dacl_events.sv
module dacl_events (
  input  logic clk,
  input  logic rst_n,
  input  logic act,
  input  logic load_n_s,
  output logic wr_end,
  output logic wr_auto,
  output logic ld_fall
);
  logic act_q, load_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      load_q <= 1'b1;
    end else begin
      act_q  <= act;
      load_q <= load_n_s;
    end
  end

  always_comb begin
    wr_end  = act_q & ~act;
    wr_auto = wr_end & ~load_n_s;
    ld_fall = load_q & ~load_n_s;
  end
endmodule

// File: rtl/dacl_regs.sv
module dacl_regs #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         zero_n,
  input  logic         por_n,
  input  logic         wr_end,
  input  logic         wr_auto,
  input  logic         ld_fall,
  input  logic [W-1:0] data_s,
  output logic [W-1:0] code_q,
  output logic         pend_q,
  output logic         upd_q
);
  logic [W-1:0] in_q, in_d, code_d;
  logic         pend_d, upd_d, en;

  always_comb begin
    in_d   = in_q;
    code_d = code_q;
    pend_d = pend_q;
    upd_d  = 1'b0;
    en     = !por_n || wr_end || ld_fall;
    if (!por_n) begin
      in_d   = '0;
      code_d = '0;
      pend_d = 1'b0;
    end else if (wr_end) begin
      in_d = data_s;
      if (wr_auto) begin
        code_d = data_s;
        pend_d = 1'b0;
        upd_d  = 1'b1;
      end else begin
        pend_d = 1'b1;
      end
    end else if (ld_fall) begin
      code_d = in_q;
      pend_d = 1'b0;
      upd_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n or negedge zero_n) begin
    if (!rst_n) begin
      in_q   <= '0;
      code_q <= '0;
      pend_q <= 1'b0;
      upd_q  <= 1'b0;
    end else if (!zero_n) begin
      in_q   <= '0;
      code_q <= '0;
      pend_q <= 1'b0;
      upd_q  <= 1'b0;
    end else begin
      upd_q <= upd_d;
      if (en) begin
        in_q   <= in_d;
        code_q <= code_d;
        pend_q <= pend_d;
      end
    end
  end
endmodule

// File: rtl/dac_loader.sv
module dac_loader
  import dacl_pkg::*;
#(
  parameter int unsigned CODE_W      = CODE_W_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_DEF,
  parameter int unsigned POR_CYCLES  = POR_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] bus_d,
  input  logic              sel_n,
  input  logic              wstb_n,
  input  logic              load_n,
  input  logic              zero_n,
  output logic [CODE_W-1:0] code_out,
  output logic              code_upd
);
  localparam int unsigned STB_W = $bits(strobe_t);

  logic              rst_s_n, por_n, pending;
  strobe_t           strb_raw, strb_s;
  logic [CODE_W-1:0] data_s;
  logic              act, wr_end, wr_auto, ld_fall;

  always_comb begin
    strb_raw.sel_n  = sel_n;
    strb_raw.wstb_n = wstb_n;
    strb_raw.load_n = load_n;
  end

  dacl_por #(.CYCLES(POR_CYCLES)) u_por (
    .clk(clk), .rst_n(rst_n), .rst_s_n(rst_s_n), .por_n(por_n)
  );

  dacl_sync #(.W(STB_W), .STAGES(SYNC_STAGES), .RST_VAL(STROBE_IDLE)) u_sync_stb (
    .clk(clk), .rst_n(rst_s_n), .d(strb_raw), .q(strb_s)
  );

  dacl_sync #(.W(CODE_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_dat (
    .clk(clk), .rst_n(rst_s_n), .d(bus_d), .q(data_s)
  );

  assign act = ~strb_s.sel_n & ~strb_s.wstb_n;

  dacl_events u_evt (
    .clk(clk), .rst_n(rst_s_n), .act(act), .load_n_s(strb_s.load_n),
    .wr_end(wr_end), .wr_auto(wr_auto), .ld_fall(ld_fall)
  );

  dacl_regs #(.W(CODE_W)) u_regs (
    .clk(clk), .rst_n(rst_s_n), .zero_n(zero_n), .por_n(por_n),
    .wr_end(wr_end), .wr_auto(wr_auto), .ld_fall(ld_fall), .data_s(data_s),
    .code_q(code_out), .pend_q(pending), .upd_q(code_upd)
  );
endmodule

// File: rtl/dacl_chk.sv
module dacl_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         zero_n,
  input logic         por_n,
  input logic         pending,
  input logic [W-1:0] code,
  input logic         upd
);
  // R1: power-on window keeps the output at zero with no update pulse
  assert_por_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !por_n |-> (code == '0 && !upd));

  // R4: every transfer leaves no deferred write outstanding
  assert_pending_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    upd |-> !pending);

  // R6: clear held low means a zero code
  assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !zero_n |-> code == '0);

  // R7: code moves only together with a pulse (clear aside)
  assert_code_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_n && $past(zero_n) && !upd) |-> $stable(code));

  // R7: no pulse during clear
  assert_no_pulse_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !zero_n |-> !upd);
endmodule

bind dac_loader dacl_chk #(.W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .zero_n(zero_n), .por_n(por_n),
  .pending(pending), .code(code_out), .upd(code_upd)
);

// File: tb/tb_dac_loader.sv
module tb_dac_loader;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n, sel_n, wstb_n, load_n, zero_n;
  logic [7:0] bus_d;
  logic [7:0] code_out;
  logic       code_upd;

  int   checks = 0;
  int   errors = 0;
  bit   finished = 0;
  logic [7:0] exp_in  = 8'h00;
  logic [7:0] exp_dac = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_loader dut (
    .clk(clk), .rst_n(rst_n), .bus_d(bus_d), .sel_n(sel_n), .wstb_n(wstb_n),
    .load_n(load_n), .zero_n(zero_n), .code_out(code_out), .code_upd(code_upd)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // shared timing check after the causing strobe edge at the current negedge
  task automatic watch_transfer(input logic [7:0] old_v, input bit expect_pulse, input string tag);
    idle(2);
    chk(code_out === old_v, {"R8 early ", tag}, code_out, old_v);
    chk(code_upd === 1'b0, {"R8 early pulse ", tag}, code_upd, 0);
    idle(1);
    chk(code_out === exp_dac, {tag, " code"}, code_out, exp_dac);
    chk(code_upd === expect_pulse, {"R7 pulse ", tag}, code_upd, expect_pulse);
    idle(1);
    chk(code_upd === 1'b0, "R7 pulse width", code_upd, 0);
  endtask

  task automatic load_fall(input string tag);
    logic [7:0] old_v;
    if (load_n !== 1'b1) begin
      load_n = 1'b1;
      idle(4);
    end
    old_v   = exp_dac;
    load_n  = 1'b0;
    exp_dac = exp_in;
    watch_transfer(old_v, 1'b1, tag);
  endtask

  task automatic do_write(input logic [7:0] val, input logic ld_lvl, input bit end_by_sel);
    logic [7:0] old_v;
    if (ld_lvl == 1'b0 && load_n === 1'b1) load_fall("R5 pre-write load");
    bus_d  = val;
    load_n = ld_lvl;
    sel_n  = 1'b0;
    wstb_n = 1'b0;
    idle(3);
    if (end_by_sel) sel_n = 1'b1;
    else            wstb_n = 1'b1;
    old_v  = exp_dac;
    exp_in = val;
    if (!ld_lvl) exp_dac = val;
    watch_transfer(old_v, !ld_lvl, ld_lvl ? "R4 deferred hold" : "R3 immediate");
    bus_d  = 8'($urandom);
    sel_n  = 1'b1;
    wstb_n = 1'b1;
    idle(4);
    chk(code_out === exp_dac, "R2 bus after end ignored", code_out, exp_dac);
  endtask

  task automatic stray_write(input logic [7:0] val);
    bus_d  = val;
    wstb_n = 1'b0;
    idle(3);
    wstb_n = 1'b1;
    idle(5);
    chk(code_out === exp_dac, "R2 strobe without select", code_out, exp_dac);
    chk(code_upd === 1'b0, "R2 no pulse on stray", code_upd, 0);
  endtask

  task automatic do_clear();
    zero_n = 1'b0;
    #1;
    chk(code_out === 8'h00, "R6 async clear", code_out, 0);
    exp_in  = 8'h00;
    exp_dac = 8'h00;
    idle(3);
    chk(code_upd === 1'b0, "R7 no pulse on clear", code_upd, 0);
    zero_n = 1'b1;
    idle(4);
    chk(code_out === 8'h00, "R6 zero after release", code_out, 0);
  endtask

  initial begin
    void'($urandom(32'h5eed_0d41));
    rst_n = 1'b0; sel_n = 1'b1; wstb_n = 1'b1; load_n = 1'b1; zero_n = 1'b1; bus_d = 8'h00;
    idle(3);
    chk(code_out === 8'h00, "R1 reset code", code_out, 0);
    chk(code_upd === 1'b0, "R1 reset pulse", code_upd, 0);
    rst_n = 1'b1;
    // write inside the power-on window must vanish
    idle(1);
    bus_d = 8'hA5; load_n = 1'b0; sel_n = 1'b0; wstb_n = 1'b0;
    idle(2);
    wstb_n = 1'b1; sel_n = 1'b1;
    idle(35);
    chk(code_out === 8'h00, "R1 write in power-on ignored", code_out, 0);
    load_fall("R1 input register zero");

    do_write(8'h80, 1'b0, 1'b0);
    do_write(8'h01, 1'b0, 1'b1);
    do_write(8'h3C, 1'b1, 1'b0);
    load_fall("R4 deferred release");
    load_fall("R5 reload no pending");
    stray_write(8'h77);
    load_fall("R2 stray not captured");
    do_write(8'hFF, 1'b1, 1'b1);
    do_clear();
    load_fall("R6 registers zero after clear");
    do_write(8'h5A, 1'b0, 1'b0);

    for (int i = 0; i < 160; i++) begin
      int op;
      op = $urandom_range(0, 19);
      if (op < 11)      do_write(8'($urandom), 1'($urandom), 1'($urandom));
      else if (op < 16) load_fall("R4 random load");
      else if (op < 18) stray_write(8'($urandom));
      else              do_clear();
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule